// File: doc/BRIEF.md
# Loop parameter update handshake

This block sits between a host and a periodic feedback loop. It holds the loop's working copy of the setpoint, the two gains and the inter-iteration delay. It also sequences each iteration: start, wait for the delay, launch the arithmetic, then collect its result. The host places new values on the input ports and raises a change request. The block copies those values only at an iteration boundary, once the programmed delay has elapsed. It answers with a single acknowledge and holds it until the host withdraws the request. A request can therefore never be applied twice.

When new values are applied, the stored loop history is cleared: the previous adjustment and the previous error return to zero. The block also reports whether the loop is active and how many clock cycles the last iteration took. When the run input is high, the loop leaves idle by sending one read command to the DAC. When run goes low, the loop drops back to idle at the next iteration boundary. The arithmetic and the converter interfaces sit outside this block. The block talks to them through a launch pulse, a done strobe and the history inputs.

The setpoint is an 18-bit two's-complement value. Each gain is 64-bit two's-complement fixed point, with 21 integer and 43 fractional bits. The delay is a 16-bit unsigned count of clock cycles.

Top module: `loop_param_sync`

## Requirements
- R1: While `rst_n` is low (synchronous), `chg_ack`, all four shadow outputs, `adj_prev`, `err_prev`, `cycle_count`, `dac_start`, `iter_go` and `in_loop` are 0.
- R2: From idle, with `run_req` high, the block raises `dac_start` and holds it until `dac_done`, with `dac_cmd` = 24'h900000. That value is bit 23 = 1, bits 22:20 = 3'b001 and bits 19:0 = 0.
- R3: In the iteration start phase, the block waits `delay_o` extra cycles and then pulses `iter_go` for one cycle. The iteration then lasts until `iter_done` is seen.
- R4: On the cycle `iter_done` is accepted, `cycle_count` is loaded with the number of clock edges since the previous iteration boundary. With a done strobe that arrives 3 cycles after launch, this equals `delay_o` + 5.
- R5: If `chg_req` is high and `chg_ack` is low when the delay has elapsed at iteration start, the block copies `setpt_in`, `kp_in`, `ki_in` and `delay_in` to the shadow outputs. On the same edge it raises `chg_ack`, together with `iter_go`.
- R6: Applying new values sets `adj_prev` and `err_prev` to 0.
- R7: While `chg_req` and `chg_ack` are both high, the shadow outputs do not change, even if the inputs change.
- R8: `chg_ack` falls only after `chg_req` is low, outside the iteration start phase.
- R9: A request withdrawn before an iteration boundary applies nothing and never raises `chg_ack`.
- R10: If `run_req` is low at iteration start, `in_loop` falls and the block returns to idle. Raising `run_req` again issues a new DAC read command.
- R11: `in_loop` is high from the edge that leaves idle until the return to idle.
- R12: When `iter_done` is accepted without a new application of values, `adj_prev` and `err_prev` take `adj_in` and `err_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_req | input | 1 | Keep the loop running |
| chg_req | input | 1 | Host change request |
| setpt_in | input | 18 | New setpoint, two's complement |
| kp_in | input | 64 | New proportional gain, Q21.43 |
| ki_in | input | 64 | New integral gain, Q21.43 |
| delay_in | input | 16 | New delay in cycles |
| chg_ack | output | 1 | Change acknowledge |
| setpt_o | output | 18 | Active setpoint |
| kp_o | output | 64 | Active proportional gain |
| ki_o | output | 64 | Active integral gain |
| delay_o | output | 16 | Active delay |
| dac_cmd | output | 24 | Command word to the DAC master |
| dac_start | output | 1 | DAC transfer request |
| dac_done | input | 1 | DAC transfer finished |
| iter_go | output | 1 | One-cycle launch of loop arithmetic |
| iter_done | input | 1 | Arithmetic finished |
| adj_in | input | 64 | New adjustment from arithmetic |
| err_in | input | 21 | New error from arithmetic |
| adj_prev | output | 64 | Stored previous adjustment |
| err_prev | output | 21 | Stored previous error |
| in_loop | output | 1 | Loop active |
| cycle_count | output | 18 | Length of last iteration in cycles |

## Verification
The assertions check on every cycle that the acknowledge rises only with a launch pulse and only while requested. They also check that it falls only after the request is gone, and that the shadows never move except on that rise. Cleared history on application, the DAC command word and a loop exit only with run low are checked the same way. Only the bench scenarios can show the timing of the delay and the value of the cycle count, and that a withdrawn request is ignored. They also show that history is captured when no change is applied, that restarting the loop sends a fresh DAC read, and the reset values.

// File: rtl/loop_param_sync.sv
module loop_param_sync #(
  parameter int SETPT_W = 18,
  parameter int GAIN_W  = 64,
  parameter int DELAY_W = 16,
  parameter int CNT_W   = 18,
  parameter int ERR_W   = 21,
  parameter int CMD_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_req,
  input  logic               chg_req,
  input  logic [SETPT_W-1:0] setpt_in,
  input  logic [GAIN_W-1:0]  kp_in,
  input  logic [GAIN_W-1:0]  ki_in,
  input  logic [DELAY_W-1:0] delay_in,
  output logic               chg_ack,
  output logic [SETPT_W-1:0] setpt_o,
  output logic [GAIN_W-1:0]  kp_o,
  output logic [GAIN_W-1:0]  ki_o,
  output logic [DELAY_W-1:0] delay_o,
  output logic [CMD_W-1:0]   dac_cmd,
  output logic               dac_start,
  input  logic               dac_done,
  output logic               iter_go,
  input  logic               iter_done,
  input  logic [GAIN_W-1:0]  adj_in,
  input  logic [ERR_W-1:0]   err_in,
  output logic [GAIN_W-1:0]  adj_prev,
  output logic [ERR_W-1:0]   err_prev,
  output logic               in_loop,
  output logic [CNT_W-1:0]   cycle_count
);
  localparam logic [CMD_W-1:0] CMD_RD = {1'b1, 3'b001, {(CMD_W-4){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_DAC, S_START, S_BUSY} st_t;
  st_t state;
  logic [DELAY_W-1:0] timer;
  logic [CNT_W-1:0]   run_cnt;

  assign in_loop = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      timer       <= '0;
      run_cnt     <= '0;
      chg_ack     <= 1'b0;
      setpt_o     <= '0;
      kp_o        <= '0;
      ki_o        <= '0;
      delay_o     <= '0;
      dac_cmd     <= '0;
      dac_start   <= 1'b0;
      iter_go     <= 1'b0;
      adj_prev    <= '0;
      err_prev    <= '0;
      cycle_count <= '0;
    end else begin
      iter_go <= 1'b0;
      if (state != S_IDLE) run_cnt <= run_cnt + 1'b1;
      if (state != S_START && !chg_req && chg_ack) chg_ack <= 1'b0;
      case (state)
        S_IDLE: if (run_req) begin
          dac_cmd   <= CMD_RD;
          dac_start <= 1'b1;
          state     <= S_DAC;
        end
        S_DAC: if (dac_done) begin
          dac_start <= 1'b0;
          timer     <= '0;
          run_cnt   <= '0;
          state     <= S_START;
        end
        S_START: begin
          if (!run_req) begin
            timer <= '0;
            state <= S_IDLE;
          end else if (timer < delay_o) begin
            timer <= timer + 1'b1;
          end else begin
            if (chg_req && !chg_ack) begin
              setpt_o  <= setpt_in;
              kp_o     <= kp_in;
              ki_o     <= ki_in;
              delay_o  <= delay_in;
              chg_ack  <= 1'b1;
              adj_prev <= '0;
              err_prev <= '0;
            end
            iter_go <= 1'b1;
            state   <= S_BUSY;
          end
        end
        S_BUSY: if (iter_done) begin
          adj_prev    <= adj_in;
          err_prev    <= err_in;
          cycle_count <= run_cnt + 1'b1;
          run_cnt     <= '0;
          timer       <= '0;
          state       <= S_START;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/loop_param_sync_chk.sv
module loop_param_sync_chk #(
  parameter int SETPT_W = 18,
  parameter int GAIN_W  = 64,
  parameter int DELAY_W = 16,
  parameter int ERR_W   = 21,
  parameter int CMD_W   = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run_req,
  input logic               chg_req,
  input logic               chg_ack,
  input logic [SETPT_W-1:0] setpt_o,
  input logic [GAIN_W-1:0]  kp_o,
  input logic [GAIN_W-1:0]  ki_o,
  input logic [DELAY_W-1:0] delay_o,
  input logic [CMD_W-1:0]   dac_cmd,
  input logic               dac_start,
  input logic               iter_go,
  input logic [GAIN_W-1:0]  adj_prev,
  input logic [ERR_W-1:0]   err_prev,
  input logic               in_loop
);
  localparam logic [CMD_W-1:0] RD_WORD = {1'b1, 3'b001, {(CMD_W-4){1'b0}}};

  assert_dac_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dac_start |-> dac_cmd == RD_WORD);
  assert_go_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iter_go |=> !iter_go);
  assert_ack_with_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_ack) |-> iter_go && $past(chg_req));
  assert_hist_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_ack) |-> adj_prev == '0 && err_prev == '0);
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(chg_ack) |-> $stable(setpt_o) && $stable(kp_o) && $stable(ki_o) && $stable(delay_o));
  assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chg_ack) |-> !$past(chg_req));
  assert_exit_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_loop) |-> !$past(run_req));
endmodule

bind loop_param_sync loop_param_sync_chk #(
  .SETPT_W(SETPT_W), .GAIN_W(GAIN_W), .DELAY_W(DELAY_W), .ERR_W(ERR_W), .CMD_W(CMD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run_req(run_req), .chg_req(chg_req), .chg_ack(chg_ack),
  .setpt_o(setpt_o), .kp_o(kp_o), .ki_o(ki_o), .delay_o(delay_o),
  .dac_cmd(dac_cmd), .dac_start(dac_start), .iter_go(iter_go),
  .adj_prev(adj_prev), .err_prev(err_prev), .in_loop(in_loop)
);

// File: tb/loop_param_sync_bench.sv
module loop_param_sync_bench;
  localparam int LAT = 3;
  localparam logic [63:0] ADJ = 64'h0123_4567_89AB_CDEF;
  localparam logic [20:0] ERR = 21'h1A5C3;
  localparam int NV = 4;
  localparam logic [17:0] T_SP [NV] = '{18'h00010, 18'h3FFF0, 18'h1FFFF, 18'h20000};
  localparam logic [63:0] T_KP [NV] = '{64'h0000_0800_0000_0000, 64'hFFFF_F000_0000_0000,
                                        64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001};
  localparam logic [63:0] T_KI [NV] = '{64'h0000_0C00_0000_0000, 64'h0000_0000_0000_0000,
                                        64'h8000_0000_0000_0000, 64'h0000_1234_5678_9ABC};
  localparam logic [15:0] T_DL [NV] = '{16'd3, 16'd0, 16'd12, 16'd7};

  logic clk = 0, rst_n = 0, run_req = 0, chg_req = 0;
  logic [17:0] setpt_in = 0;
  logic [63:0] kp_in = 0, ki_in = 0, adj_prev;
  logic [15:0] delay_in = 0, delay_o;
  logic chg_ack, dac_start, dac_done, iter_go, iter_done, in_loop;
  logic [17:0] setpt_o, cycle_count;
  logic [63:0] kp_o, ki_o;
  logic [23:0] dac_cmd;
  logic [20:0] err_prev;
  logic dac_q;
  int   busy_cnt;
  bit   ack_seen;
  int   n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  loop_param_sync u_loop_param_sync (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .chg_req(chg_req),
    .setpt_in(setpt_in), .kp_in(kp_in), .ki_in(ki_in), .delay_in(delay_in),
    .chg_ack(chg_ack), .setpt_o(setpt_o), .kp_o(kp_o), .ki_o(ki_o), .delay_o(delay_o),
    .dac_cmd(dac_cmd), .dac_start(dac_start), .dac_done(dac_done),
    .iter_go(iter_go), .iter_done(iter_done), .adj_in(ADJ), .err_in(ERR),
    .adj_prev(adj_prev), .err_prev(err_prev), .in_loop(in_loop), .cycle_count(cycle_count)
  );

  always @(posedge clk) begin
    if (!rst_n) begin dac_q <= 0; busy_cnt <= 0; end
    else begin
      dac_q <= dac_start;
      if (iter_go) busy_cnt <= LAT;
      else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (chg_ack) ack_seen <= 1;
    end
  end
  assign dac_done  = dac_q;
  assign iter_done = (busy_cnt == 1);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_sig(input int which, input logic val, output bit hit);
    hit = 0;
    for (int i = 0; i < 3000 && !hit; i++) begin
      @(negedge clk);
      case (which)
        0: hit = (chg_ack == val);
        1: hit = (iter_go == val);
        2: hit = (dac_start == val);
        default: hit = (in_loop == val);
      endcase
    end
  endtask

  task automatic wait_iter_end();
    bit hit = 0;
    for (int i = 0; i < 3000 && !hit; i++) begin
      @(negedge clk);
      hit = iter_done;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    bit hit;
    repeat (3) @(negedge clk);
    chk(chg_ack == 0 && setpt_o == 0 && kp_o == 0 && ki_o == 0 && delay_o == 0,
        "R1 reset shadows/ack", {setpt_o, delay_o}, 0);
    chk(adj_prev == 0 && err_prev == 0 && cycle_count == 0 && !in_loop && !dac_start && !iter_go,
        "R1 reset loop state", adj_prev, 0);
    rst_n = 1;
    run_req = 1;
    wait_sig(2, 1'b1, hit);
    chk(hit && dac_cmd == 24'h900000, "R2 dac read command", dac_cmd, 24'h900000);
    chk(in_loop, "R11 in_loop while running", in_loop, 1);

    for (int v = 0; v < NV; v++) begin
      setpt_in = T_SP[v]; kp_in = T_KP[v]; ki_in = T_KI[v]; delay_in = T_DL[v];
      chg_req = 1;
      wait_sig(0, 1'b1, hit);
      chk(hit && iter_go, "R5 ack with launch", iter_go, 1);
      chk(setpt_o == T_SP[v] && kp_o == T_KP[v] && ki_o == T_KI[v] && delay_o == T_DL[v],
          "R5 values applied", kp_o, T_KP[v]);
      chk(adj_prev == 0 && err_prev == 0, "R6 history cleared", adj_prev, 0);
      setpt_in = ~T_SP[v]; kp_in = ~T_KP[v]; ki_in = ~T_KI[v]; delay_in = T_DL[v] + 16'd9;
      wait_iter_end();
      chk(adj_prev == ADJ && err_prev == ERR, "R12 history captured", adj_prev, ADJ);
      wait_iter_end();
      chk(cycle_count == 18'(T_DL[v]) + 18'd5, "R4 cycle count / R3 delay", cycle_count, T_DL[v] + 5);
      chk(setpt_o == T_SP[v] && kp_o == T_KP[v] && delay_o == T_DL[v],
          "R7 held while req and ack high", kp_o, T_KP[v]);
      chg_req = 0;
      wait_sig(0, 1'b0, hit);
      chk(hit, "R8 ack released", chg_ack, 0);
    end

    wait_sig(1, 1'b1, hit);
    ack_seen = 0;
    setpt_in = 18'h0AAAA; kp_in = 64'h5; ki_in = 64'h6; delay_in = 16'd2;
    chg_req = 1;
    @(negedge clk);
    chg_req = 0;
    wait_iter_end();
    wait_iter_end();
    chk(!ack_seen && setpt_o == T_SP[NV-1] && delay_o == T_DL[NV-1],
        "R9 withdrawn request ignored", setpt_o, T_SP[NV-1]);

    run_req = 0;
    wait_sig(3, 1'b0, hit);
    chk(hit && !in_loop, "R10 loop stops", in_loop, 0);
    repeat (5) @(negedge clk);
    chk(!dac_start && !in_loop, "R10 stays idle while stopped", dac_start, 0);
    run_req = 1;
    wait_sig(2, 1'b1, hit);
    chk(hit && dac_cmd == 24'h900000 && in_loop, "R10 restart issues dac read", dac_cmd, 24'h900000);

    wait_iter_end();
    rst_n = 0;
    @(negedge clk);
    chk(!chg_ack && setpt_o == 0 && kp_o == 0 && cycle_count == 0 && !in_loop && adj_prev == 0,
        "R1 reset while running", cycle_count, 0);
    rst_n = 1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule